// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block performs the state changes a processor core makes when it takes an exception, on a machine with four privilege levels. Level 0 is the least privileged and each higher number is more privileged. A request carries a wanted target level, an exception class, the register width of the interrupted code and a return address. The unit first settles the real target level. It then writes that level's banked link register and saved status word, sets every interrupt mask, moves the core to the target level using that level's own stack pointer, and sends a one-cycle fetch redirect to the handler slot in the target level's vector table.

The handler slot depends on two things. One is the class. The other is where the exception came from: the same level using the level-0 stack, the same level using its own stack, a lower level running 64-bit code, or a lower level running 32-bit code. Each slot is 128 bytes, so a short handler fits inside the slot. The vector bases are set through a small write port. A context-load port puts the level, stack choice and masks into the unit, as a return path or boot code would. A read port shows the banked registers of any level.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the unit is at level 3, using its own stack, with all four mask bits set. The redirect is low, and every vector base, link register and saved status word reads zero.
- R2: The target level is the larger of the requested level and the current level. An exception never lowers the level.
- R3: A target that resolves to level 0 is promoted to level 1. Level 0 is never entered through an exception.
- R4: On entry, the link register of the target level receives the return address. When the width flag `req_is32` is 1, only bits 31:0 are kept and the upper bits are stored as zero.
- R5: On entry, the saved status word of the target level captures the state from before entry. Bits 3:0 hold the masks, bits 5:4 the level, bit 6 the own-stack flag and bit 7 the width flag of the request.
- R6: After entry, the current level equals the resolved target, the own-stack flag is 1 and all four mask bits are 1.
- R7: The handler address is the target vector base + 0x200 × group + 0x80 × class. The classes are synchronous=0, IRQ=1, FIQ=2 and error=3. The groups are: 0 for the same level using the level-0 stack, 1 for the same level using its own stack, 2 for a lower level running 64-bit code, and 3 for a lower level running 32-bit code.
- R8: `redirect` is high for exactly the one cycle after each clock edge that samples `req_valid`, and `redirect_addr` is valid in that cycle.
- R9: A write to the vector base of level 1, 2 or 3 stores the data with bits 10:0 forced to zero. A write that selects level 0 has no effect.
- R10: `ctx_load` sets the level, own-stack flag and masks. When `ctx_load` and `req_valid` are high in the same cycle, the exception entry wins.
- R11: The read port returns the vector base, link register and saved status word of the level on `rd_level`. Level 0 returns zero for all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Take an exception this cycle |
| req_target | input | 2 | Requested target level |
| req_class | input | 2 | Exception class code |
| req_is32 | input | 1 | Interrupted code used 32-bit registers |
| req_ret_pc | input | 64 | Return address |
| ctx_load | input | 1 | Load current context |
| ctx_level | input | 2 | Level to load |
| ctx_sp_own | input | 1 | Own-stack flag to load |
| ctx_masks | input | 4 | Mask bits to load |
| vb_we | input | 1 | Vector base write enable |
| vb_sel | input | 2 | Level whose vector base is written |
| vb_wdata | input | 64 | Vector base write data |
| rd_level | input | 2 | Level shown on the read port |
| rd_vbase | output | 64 | Vector base of `rd_level` |
| rd_link | output | 64 | Link register of `rd_level` |
| rd_saved | output | 8 | Saved status word of `rd_level` |
| cur_level | output | 2 | Current privilege level |
| cur_sp_own | output | 1 | Current level uses its own stack |
| cur_masks | output | 4 | Current interrupt mask bits |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | 64 | Handler fetch address |

## Verification
Each result of an exception entry sits in a register that is written at the clock edge that samples `req_valid`. The redirect, the handler address, the new level, stack flag and masks, and the banked link and saved words are therefore all due one cycle after the request is driven. The bench drives inputs on the falling edge and samples them on the next falling edge. It then checks once more, one cycle later, that the redirect has dropped. The read port and a vector base write take effect at the same edge, so each write is read back half a cycle after it is clocked in.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int LVL_W   = 2;
   localparam int MASK_W  = 4;
   localparam int SAVED_W = 8;

   typedef enum logic [1:0] {
      CLS_SYNC  = 2'd0,
      CLS_IRQ   = 2'd1,
      CLS_FIQ   = 2'd2,
      CLS_ERROR = 2'd3
   } exc_class_e;

   typedef struct packed {
      logic              is32;
      logic              sp_own;
      logic [LVL_W-1:0]  level;
      logic [MASK_W-1:0] masks;
   } saved_word_t;
endpackage

// File: rtl/exc_target_resolve.sv
module exc_target_resolve
   import exc_pkg::*;
(
   input  logic [LVL_W-1:0] cur_level,
   input  logic [LVL_W-1:0] req_target,
   output logic [LVL_W-1:0] tgt_level,
   output logic             from_lower
);
   logic [LVL_W-1:0] raised;

   always_comb begin
      raised     = (req_target > cur_level) ? req_target : cur_level;
      tgt_level  = (raised == '0) ? LVL_W'(1) : raised;
      from_lower = (tgt_level != cur_level);
   end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
   import exc_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SLOT_BYTES = 128
) (
   input  logic [ADDR_W-1:0] vbase,
   input  logic              from_lower,
   input  logic              sp_own,
   input  logic              is32,
   input  logic [1:0]        cls,
   output logic [ADDR_W-1:0] handler
);
   localparam int SLOT_SH = $clog2(SLOT_BYTES);

   logic [1:0]        group;
   logic [ADDR_W-1:0] offset;

   always_comb begin
      group   = from_lower ? {1'b1, is32} : {1'b0, sp_own};
      offset  = ADDR_W'({group, cls}) << SLOT_SH;
      handler = vbase + offset;
   end
endmodule

// File: rtl/exc_bank_regs.sv
module exc_bank_regs
   import exc_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int NUM_LEVELS = 4,
   parameter int ALIGN_BITS = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vb_we,
   input  logic [LVL_W-1:0]   vb_sel,
   input  logic [ADDR_W-1:0]  vb_wdata,
   input  logic               ent_we,
   input  logic [LVL_W-1:0]   ent_level,
   input  logic [ADDR_W-1:0]  ent_link,
   input  logic [SAVED_W-1:0] ent_saved,
   input  logic [LVL_W-1:0]   tgt_level,
   output logic [ADDR_W-1:0]  tgt_vbase,
   input  logic [LVL_W-1:0]   rd_level,
   output logic [ADDR_W-1:0]  rd_vbase,
   output logic [ADDR_W-1:0]  rd_link,
   output logic [SAVED_W-1:0] rd_saved
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

   logic [ADDR_W-1:0]  vbase_q [NUM_LEVELS];
   logic [ADDR_W-1:0]  link_q  [NUM_LEVELS];
   logic [SAVED_W-1:0] saved_q [NUM_LEVELS];

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_user
         assign vbase_q[g] = '0;
         assign link_q[g]  = '0;
         assign saved_q[g] = '0;
      end else begin : g_priv
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vbase_q[g] <= '0;
               link_q[g]  <= '0;
               saved_q[g] <= '0;
            end else begin
               if (vb_we && vb_sel == LVL_W'(g))
                  vbase_q[g] <= vb_wdata & ALIGN_MASK;
               if (ent_we && ent_level == LVL_W'(g)) begin
                  link_q[g]  <= ent_link;
                  saved_q[g] <= ent_saved;
               end
            end
         end
         // R9: a stored base never has any of its low bits set
         assert_base_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (vb_we && vb_sel == LVL_W'(g)) |=> (vbase_q[g][ALIGN_BITS-1:0] == '0));
      end
   end

   assign tgt_vbase = vbase_q[tgt_level];
   assign rd_vbase  = vbase_q[rd_level];
   assign rd_link   = link_q[rd_level];
   assign rd_saved  = saved_q[rd_level];
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int NUM_LEVELS = 4,
   parameter int SLOT_BYTES = 128,
   parameter int ALIGN_BITS = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_target,
   input  logic [1:0]    req_class,
   input  logic          req_is32,
   input  logic [63:0]   req_ret_pc,
   input  logic          ctx_load,
   input  logic [1:0]    ctx_level,
   input  logic          ctx_sp_own,
   input  logic [3:0]    ctx_masks,
   input  logic          vb_we,
   input  logic [1:0]    vb_sel,
   input  logic [63:0]   vb_wdata,
   input  logic [1:0]    rd_level,
   output logic [63:0]   rd_vbase,
   output logic [63:0]   rd_link,
   output logic [7:0]    rd_saved,
   output logic [1:0]    cur_level,
   output logic          cur_sp_own,
   output logic [3:0]    cur_masks,
   output logic          redirect,
   output logic [63:0]   redirect_addr
);
   localparam int HALF_W = 32;

   if (NUM_LEVELS != 4) begin : g_bad_levels
      $error("exc_entry_unit: NUM_LEVELS must be 4");
   end
   if (ADDR_W != 64) begin : g_bad_width
      $error("exc_entry_unit: ADDR_W must be 64 to match the port widths");
   end
   if ((1 << $clog2(SLOT_BYTES)) != SLOT_BYTES || SLOT_BYTES * 16 > (1 << ALIGN_BITS)) begin : g_bad_slot
      $error("exc_entry_unit: SLOT_BYTES must be a power of two whose 16 slots fit the base alignment");
   end

   logic [LVL_W-1:0]  tgt_level;
   logic              from_lower;
   logic [ADDR_W-1:0] tgt_vbase;
   logic [ADDR_W-1:0] handler;
   logic [ADDR_W-1:0] link_val;
   saved_word_t       saved_val;

   exc_target_resolve u_resolve (
      .cur_level  (cur_level),
      .req_target (req_target),
      .tgt_level  (tgt_level),
      .from_lower (from_lower)
   );

   exc_vector_calc #(.ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES)) u_vec (
      .vbase      (tgt_vbase),
      .from_lower (from_lower),
      .sp_own     (cur_sp_own),
      .is32       (req_is32),
      .cls        (req_class),
      .handler    (handler)
   );

   always_comb begin
      link_val         = req_is32 ? {{(ADDR_W-HALF_W){1'b0}}, req_ret_pc[HALF_W-1:0]} : req_ret_pc;
      saved_val.is32   = req_is32;
      saved_val.sp_own = cur_sp_own;
      saved_val.level  = cur_level;
      saved_val.masks  = cur_masks;
   end

   exc_bank_regs #(.ADDR_W(ADDR_W), .NUM_LEVELS(NUM_LEVELS), .ALIGN_BITS(ALIGN_BITS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .vb_we     (vb_we),
      .vb_sel    (vb_sel),
      .vb_wdata  (vb_wdata),
      .ent_we    (req_valid),
      .ent_level (tgt_level),
      .ent_link  (link_val),
      .ent_saved (saved_val),
      .tgt_level (tgt_level),
      .tgt_vbase (tgt_vbase),
      .rd_level  (rd_level),
      .rd_vbase  (rd_vbase),
      .rd_link   (rd_link),
      .rd_saved  (rd_saved)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_level     <= LVL_W'(NUM_LEVELS - 1);
         cur_sp_own    <= 1'b1;
         cur_masks     <= '1;
         redirect      <= 1'b0;
         redirect_addr <= '0;
      end else begin
         redirect <= req_valid;
         if (req_valid) begin
            cur_level     <= tgt_level;
            cur_sp_own    <= 1'b1;
            cur_masks     <= '1;
            redirect_addr <= handler;
         end else if (ctx_load) begin
            cur_level  <= ctx_level;
            cur_sp_own <= ctx_sp_own;
            cur_masks  <= ctx_masks;
         end
      end
   end

   // R8: one redirect cycle per sampled request, none otherwise
   assert_redirect_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> redirect);
   assert_redirect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !redirect);
   // R2: entry never lowers the level
   assert_level_not_lowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (cur_level >= $past(cur_level)));
   // R3: level 0 is never reached by an exception
   assert_no_entry_to_level0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (cur_level != '0));
   // R6: masks all set and own stack after entry
   assert_masks_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (cur_masks == '1 && cur_sp_own));
   // R7: handler address falls on a slot boundary
   assert_slot_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (redirect_addr[$clog2(SLOT_BYTES)-1:0] == '0));
endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_is32, ctx_load, ctx_sp_own, vb_we;
   logic [1:0]  req_target, req_class, ctx_level, vb_sel, rd_level;
   logic [3:0]  ctx_masks;
   logic [63:0] req_ret_pc, vb_wdata;
   logic [63:0] rd_vbase, rd_link, redirect_addr;
   logic [7:0]  rd_saved;
   logic [1:0]  cur_level;
   logic        cur_sp_own, redirect;
   logic [3:0]  cur_masks;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [63:0] vb_model [4];

   always #10 clk = ~clk;

   exc_entry_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
      .req_class(req_class), .req_is32(req_is32), .req_ret_pc(req_ret_pc),
      .ctx_load(ctx_load), .ctx_level(ctx_level), .ctx_sp_own(ctx_sp_own),
      .ctx_masks(ctx_masks), .vb_we(vb_we), .vb_sel(vb_sel), .vb_wdata(vb_wdata),
      .rd_level(rd_level), .rd_vbase(rd_vbase), .rd_link(rd_link), .rd_saved(rd_saved),
      .cur_level(cur_level), .cur_sp_own(cur_sp_own), .cur_masks(cur_masks),
      .redirect(redirect), .redirect_addr(redirect_addr)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   function automatic logic [1:0] model_target(input logic [1:0] cur, input logic [1:0] req);
      logic [1:0] t;
      t = (req > cur) ? req : cur;
      return (t == 2'd0) ? 2'd1 : t;
   endfunction

   function automatic logic [63:0] model_addr(input logic [1:0] cur, input logic sp,
                                              input logic [1:0] tgt, input logic is32,
                                              input logic [1:0] cls);
      int grp;
      if (tgt == cur) grp = sp ? 1 : 0;
      else            grp = is32 ? 3 : 2;
      return vb_model[tgt] + 64'(grp * 'h200) + 64'(cls * 'h80);
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; req_valid = 0; req_is32 = 0; ctx_load = 0; ctx_sp_own = 0; vb_we = 0;
      req_target = 0; req_class = 0; ctx_level = 0; vb_sel = 0; rd_level = 0;
      ctx_masks = 0; req_ret_pc = 0; vb_wdata = 0;
      for (int i = 0; i < 4; i++) vb_model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(64'(cur_level), 64'd3, "R1 reset level");
      chk(64'(cur_sp_own), 64'd1, "R1 reset stack flag");
      chk(64'(cur_masks), 64'hF, "R1 reset masks");
      chk(64'(redirect), 64'd0, "R1 reset redirect");
      for (int l = 0; l < 4; l++) begin
         rd_level = 2'(l);
         #1;
         chk(rd_vbase, 64'd0, "R1 reset vector base");
         chk(rd_link, 64'd0, "R1 reset link");
         chk(64'(rd_saved), 64'd0, "R1 reset saved word");
      end
   endtask

   task automatic t_write_bases();
      logic [63:0] data [4];
      data[0] = 64'h0000_0000_0000_1234;
      data[1] = 64'h0000_0000_8000_0000;
      data[2] = 64'h0000_0000_9000_0ABC;
      data[3] = 64'hFFFF_0000_0000_1FFF;
      for (int l = 0; l < 4; l++) begin
         @(negedge clk);
         vb_we = 1'b1; vb_sel = 2'(l); vb_wdata = data[l];
         if (l != 0) vb_model[l] = data[l] & ~64'h7FF;
      end
      @(negedge clk);
      vb_we = 1'b0;
      for (int l = 0; l < 4; l++) begin
         rd_level = 2'(l);
         #1;
         chk(rd_vbase, vb_model[l], (l == 0) ? "R9 level 0 base write ignored" : "R9 R11 aligned base");
      end
      rd_level = 2'd0;
      #1;
      chk(rd_link, 64'd0, "R11 level 0 link reads zero");
      chk(64'(rd_saved), 64'd0, "R11 level 0 saved reads zero");
   endtask

   task automatic t_exc(input logic [1:0] lvl, input logic sp, input logic [3:0] msk,
                        input logic [1:0] tgt_req, input logic [1:0] cls,
                        input logic is32, input logic [63:0] pc, input string name);
      logic [1:0]  et;
      logic [63:0] ea, el;
      logic [7:0]  es;
      @(negedge clk);
      ctx_load = 1'b1; ctx_level = lvl; ctx_sp_own = sp; ctx_masks = msk;
      @(negedge clk);
      ctx_load = 1'b0;
      chk(64'(cur_level), 64'(lvl), {name, " R10 context loaded"});
      et = model_target(lvl, tgt_req);
      ea = model_addr(lvl, sp, et, is32, cls);
      el = is32 ? {32'd0, pc[31:0]} : pc;
      es = {is32, sp, lvl, msk};
      req_valid = 1'b1; req_target = tgt_req; req_class = cls; req_is32 = is32; req_ret_pc = pc;
      @(negedge clk);
      req_valid = 1'b0;
      rd_level = et;
      #1;
      chk(64'(redirect), 64'd1, {name, " R8 redirect high"});
      chk(redirect_addr, ea, {name, " R7 handler address"});
      chk(64'(cur_level), 64'(et), {name, " R2 R3 R6 new level"});
      chk(64'(cur_sp_own), 64'd1, {name, " R6 own stack"});
      chk(64'(cur_masks), 64'hF, {name, " R6 masks set"});
      chk(rd_link, el, {name, " R4 link register"});
      chk(64'(rd_saved), 64'(es), {name, " R5 saved word"});
      @(negedge clk);
      chk(64'(redirect), 64'd0, {name, " R8 redirect one cycle"});
   endtask

   task automatic t_priority();
      @(negedge clk);
      ctx_load = 1'b1; ctx_level = 2'd1; ctx_sp_own = 1'b1; ctx_masks = 4'h0;
      @(negedge clk);
      ctx_level = 2'd3; ctx_sp_own = 1'b0; ctx_masks = 4'h2;
      req_valid = 1'b1; req_target = 2'd2; req_class = 2'd1; req_is32 = 1'b0;
      req_ret_pc = 64'h0000_0040_0000_1000;
      @(negedge clk);
      req_valid = 1'b0; ctx_load = 1'b0;
      #1;
      chk(64'(cur_level), 64'd2, "R10 entry wins over context load");
      chk(64'(cur_masks), 64'hF, "R10 masks from entry");
      chk(redirect_addr, vb_model[2] + 64'h480, "R10 R7 handler from pre-load state");
   endtask

   initial begin
      t_reset();
      t_write_bases();
      // lower level 0, 32-bit, target 0 promoted to 1
      t_exc(2'd0, 1'b0, 4'h0, 2'd0, 2'd1, 1'b1, 64'hDEAD_BEEF_1234_5678, "T_promote");
      // same level, own stack, FIQ
      t_exc(2'd1, 1'b1, 4'hF, 2'd1, 2'd2, 1'b0, 64'hDEAD_BEEF_1234_5678, "T_same_own");
      // same level, level-0 stack, synchronous
      t_exc(2'd1, 1'b0, 4'h5, 2'd1, 2'd0, 1'b0, 64'h0000_1111_2222_3330, "T_same_l0sp");
      // lower target request raised to current level 2
      t_exc(2'd2, 1'b1, 4'hA, 2'd1, 2'd3, 1'b0, 64'h0000_0000_0000_0400, "T_raise");
      // lower level, 64-bit, target 3
      t_exc(2'd1, 1'b0, 4'h3, 2'd3, 2'd0, 1'b0, 64'h8000_0000_0000_0008, "T_up64");
      // lower level 0, 32-bit, error class to level 2
      t_exc(2'd0, 1'b1, 4'h1, 2'd2, 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, "T_up32");
      t_priority();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule